// File: doc/BRIEF.md
# Microcontroller Parallel Port Controller

This block holds the digital control for four eight-bit general-purpose ports of a small microcontroller. Each port bit has a storage latch that the core writes over an internal bus. The block turns the latch contents into three drive controls per pin: a strong-high enable, a strong-low enable and a weak pull-up enable. Software reads can return either the stored latch byte or the resolved pin levels, which the pad ring feeds back as ordinary logic inputs.

Port 0 works as an open-drain port in normal operation. The other ports behave as quasi-bidirectional pins: a 0 pulls the pin low hard, and a 1 leaves only a weak pull-up. Three other functions can take over the pins. During external memory cycles, port 0 carries the low address byte and then the data byte. When a 16-bit address is in use, port 2 carries the high address byte. Port 1 bits that a serial channel claims become push-pull outputs or floating inputs.

Read-modify-write updates are computed from the latch and never from the pins. A bit that an outside source holds low therefore keeps its stored 1.

Top module: `par_port_ctrl`

## Requirements
- R1: After reset every latch holds 0xFF. Ports 1 to 3 then assert only the weak pull-up on every pin, and port 0 asserts no drive at all.
- R2: When `wr_en` is high with `wr_op` = 0 (load), the port chosen by `wr_sel` captures `wr_data` at the clock edge. The other latches keep their values.
- R3: `rd_data` is combinational. With `rd_src` = 1 it shows the latch of port `rd_sel`, and with `rd_src` = 0 it shows that port's `pin_in` bits.
- R4: With `ext_phase` idle (0), each port 0 pin drives strong-low when its latch bit is 0 and drives nothing when it is 1. Port 0 never drives strong-high when idle and never enables a pull-up.
- R5: On a plain quasi-bidirectional port (port 3), a latch bit of 0 gives strong-low only and a latch bit of 1 gives pull-up only. Strong-high is never asserted.
- R6: `ext_phase` codes are 0 idle, 1 address, 2 write data and 3 read data. In phase 1 port 0 drives `ext_addr[7:0]` push-pull, and in phase 2 it drives `ext_wdata` push-pull, both with no pull-up.
- R7: In phase 3 all port 0 drive controls are off. `ext_rdata` loads the port 0 pins on each clock edge in phase 3 and holds otherwise, resetting to 0. External phases never change any latch.
- R8: While `ext_phase` is not idle and `ext_wide` = 1, port 2 drives `ext_addr[15:8]` push-pull. Otherwise port 2 behaves as a quasi-bidirectional port from its latch.
- R9: For each port 1 bit with `ser_en` set, `ser_dir` = 1 drives `ser_out` push-pull and `ser_dir` = 0 turns all drive off. Bits with `ser_en` clear stay quasi-bidirectional.
- R10: `wr_op` 1, 2 and 3 replace the selected latch with latch AND, OR or XOR `wr_data`, using the stored value and not the pin level.
- R11: No pin ever has strong-high and strong-low enabled at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_sel | input | 2 | Port chosen for the write |
| wr_op | input | 2 | 0 load, 1 AND, 2 OR, 3 XOR |
| wr_data | input | 8 | Write value or operand |
| rd_sel | input | 2 | Port chosen for the read |
| rd_src | input | 1 | 1 latch, 0 pin levels |
| rd_data | output | 8 | Read result |
| ext_phase | input | 2 | External access phase |
| ext_wide | input | 1 | 16-bit external address in use |
| ext_addr | input | 16 | External address |
| ext_wdata | input | 8 | External write data |
| ext_rdata | output | 8 | Captured external read data |
| ser_en | input | 8 | Port 1 bits claimed by the serial channel |
| ser_dir | input | 8 | 1 serial output, 0 serial input |
| ser_out | input | 8 | Serial output levels |
| pin_in | input | 32 | Resolved pin levels, port p at bits 8p+7..8p |
| drv_hi | output | 32 | Strong-high enables |
| drv_lo | output | 32 | Strong-low enables |
| drv_pu | output | 32 | Weak pull-up enables |

## Verification
The assertions check on every cycle the rules that need no stored history: high and low are never enabled together, port 0 has no pull-up and goes silent during read-data phases, the plain quasi port never drives high, serial input bits float, a load write reaches the latch, and the captured read byte holds outside read phases. The bench's scenarios cover the value-level behaviour. This includes the exact drive patterns for each mix of phase, width and serial mask, and the latch-versus-pin read split when outside sources pull pins low. It also covers the read-modify-write operators keeping latch ones that the pins contradict, and the capture of read data at the end of a read phase.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ADDR  = 2'd1,
      PH_WDATA = 2'd2,
      PH_RDATA = 2'd3
   } ext_phase_e;

   typedef enum logic [1:0] {
      OP_LOAD = 2'd0,
      OP_AND  = 2'd1,
      OP_OR   = 2'd2,
      OP_XOR  = 2'd3
   } wr_op_e;

   localparam int ROLE_QUASI = 0;
   localparam int ROLE_ADDATA = 1;
   localparam int ROLE_ADHIGH = 2;
   localparam int ROLE_SERIAL = 3;
endpackage

// File: rtl/ppc_latch_bank.sv
module ppc_latch_bank
   import ppc_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8,
   parameter logic [PORT_W-1:0] RST_VAL = '1,
   localparam int SEL_W = $clog2(NUM_PORTS),
   localparam int BUS_W = NUM_PORTS * PORT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  wr_op_e            wr_op,
   input  logic [PORT_W-1:0] wr_data,
   output logic [BUS_W-1:0]  latch_q
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [PORT_W-1:0] lat;
      logic [PORT_W-1:0] nxt;
      logic              hit;

      assign hit = wr_en && (wr_sel == SEL_W'(p));

      always_comb begin
         unique case (wr_op)
            OP_LOAD: nxt = wr_data;
            OP_AND:  nxt = lat & wr_data;
            OP_OR:   nxt = lat | wr_data;
            default: nxt = lat ^ wr_data;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   lat <= RST_VAL;
         else if (hit) lat <= nxt;
      end

      assign latch_q[p*PORT_W +: PORT_W] = lat;
   end
endmodule

// File: rtl/ppc_pad_ctrl.sv
module ppc_pad_ctrl
   import ppc_pkg::*;
#(
   parameter int PORT_W = 8,
   parameter int ROLE   = ROLE_QUASI
) (
   input  logic [PORT_W-1:0] latch,
   input  ext_phase_e        phase,
   input  logic              ext_wide,
   input  logic [PORT_W-1:0] addr_lo,
   input  logic [PORT_W-1:0] addr_hi,
   input  logic [PORT_W-1:0] wdata,
   input  logic [PORT_W-1:0] ser_en,
   input  logic [PORT_W-1:0] ser_dir,
   input  logic [PORT_W-1:0] ser_out,
   output logic [PORT_W-1:0] hi,
   output logic [PORT_W-1:0] lo,
   output logic [PORT_W-1:0] pu
);
   // Weak-high / strong-low drive derived from the latch alone.
   logic [PORT_W-1:0] q_lo, q_pu;
   assign q_lo = ~latch;
   assign q_pu = latch;

   if (ROLE == ROLE_ADDATA) begin : g_addata
      logic unused_ad;
      assign unused_ad = ^{ext_wide, addr_hi, ser_en, ser_dir, ser_out, q_pu};
      always_comb begin
         hi = '0;
         lo = '0;
         pu = '0;
         unique case (phase)
            PH_IDLE:  lo = q_lo;
            PH_ADDR:  begin hi = addr_lo; lo = ~addr_lo; end
            PH_WDATA: begin hi = wdata;   lo = ~wdata;   end
            default:  ;
         endcase
      end
   end else if (ROLE == ROLE_ADHIGH) begin : g_adhigh
      logic unused_ah;
      assign unused_ah = ^{addr_lo, wdata, ser_en, ser_dir, ser_out};
      always_comb begin
         if (phase != PH_IDLE && ext_wide) begin
            hi = addr_hi;
            lo = ~addr_hi;
            pu = '0;
         end else begin
            hi = '0;
            lo = q_lo;
            pu = q_pu;
         end
      end
   end else if (ROLE == ROLE_SERIAL) begin : g_serial
      logic unused_sr;
      assign unused_sr = ^{phase, ext_wide, addr_lo, addr_hi, wdata};
      for (genvar b = 0; b < PORT_W; b++) begin : g_bit
         always_comb begin
            if (ser_en[b]) begin
               hi[b] = ser_dir[b] &  ser_out[b];
               lo[b] = ser_dir[b] & ~ser_out[b];
               pu[b] = 1'b0;
            end else begin
               hi[b] = 1'b0;
               lo[b] = q_lo[b];
               pu[b] = q_pu[b];
            end
         end
      end
   end else begin : g_quasi
      logic unused_qb;
      assign unused_qb = ^{phase, ext_wide, addr_lo, addr_hi, wdata,
                           ser_en, ser_dir, ser_out};
      assign hi = '0;
      assign lo = q_lo;
      assign pu = q_pu;
   end
endmodule

// File: rtl/ppc_read_mux.sv
module ppc_read_mux #(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8,
   localparam int SEL_W = $clog2(NUM_PORTS),
   localparam int BUS_W = NUM_PORTS * PORT_W
) (
   input  logic [BUS_W-1:0]  latch_q,
   input  logic [BUS_W-1:0]  pin_in,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic              rd_src,
   output logic [PORT_W-1:0] rd_data
);
   logic [PORT_W-1:0] lat_arr [NUM_PORTS];
   logic [PORT_W-1:0] pin_arr [NUM_PORTS];

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_split
      assign lat_arr[p] = latch_q[p*PORT_W +: PORT_W];
      assign pin_arr[p] = pin_in[p*PORT_W +: PORT_W];
   end

   always_comb begin
      rd_data = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (rd_sel == SEL_W'(p))
            rd_data = rd_src ? lat_arr[p] : pin_arr[p];
      end
   end
endmodule

// File: rtl/par_port_ctrl.sv
module par_port_ctrl
   import ppc_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8,
   parameter int AD_PORT   = 0,
   parameter int AH_PORT   = 2,
   parameter int SER_PORT  = 1,
   localparam int SEL_W  = $clog2(NUM_PORTS),
   localparam int BUS_W  = NUM_PORTS * PORT_W,
   localparam int ADDR_W = 2 * PORT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [1:0]        wr_op,
   input  logic [PORT_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic              rd_src,
   output logic [PORT_W-1:0] rd_data,
   input  logic [1:0]        ext_phase,
   input  logic              ext_wide,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic [PORT_W-1:0] ext_wdata,
   output logic [PORT_W-1:0] ext_rdata,
   input  logic [PORT_W-1:0] ser_en,
   input  logic [PORT_W-1:0] ser_dir,
   input  logic [PORT_W-1:0] ser_out,
   input  logic [BUS_W-1:0]  pin_in,
   output logic [BUS_W-1:0]  drv_hi,
   output logic [BUS_W-1:0]  drv_lo,
   output logic [BUS_W-1:0]  drv_pu
);
   if (NUM_PORTS < 3) begin : g_bad_ports
      $error("par_port_ctrl: NUM_PORTS must be at least 3");
   end
   if (PORT_W < 1) begin : g_bad_width
      $error("par_port_ctrl: PORT_W must be positive");
   end
   if (AD_PORT >= NUM_PORTS || AH_PORT >= NUM_PORTS || SER_PORT >= NUM_PORTS) begin : g_bad_role
      $error("par_port_ctrl: role port index out of range");
   end
   if (AD_PORT == AH_PORT || AD_PORT == SER_PORT || AH_PORT == SER_PORT) begin : g_dup_role
      $error("par_port_ctrl: role ports must differ");
   end

   ext_phase_e phase;
   assign phase = ext_phase_e'(ext_phase);

   logic [BUS_W-1:0] latch_q;

   ppc_latch_bank #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_op   (wr_op_e'(wr_op)),
      .wr_data (wr_data),
      .latch_q (latch_q)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pad
      localparam int ROLE = (p == AD_PORT)  ? ROLE_ADDATA :
                            (p == AH_PORT)  ? ROLE_ADHIGH :
                            (p == SER_PORT) ? ROLE_SERIAL : ROLE_QUASI;
      ppc_pad_ctrl #(
         .PORT_W (PORT_W),
         .ROLE   (ROLE)
      ) u_pad (
         .latch    (latch_q[p*PORT_W +: PORT_W]),
         .phase    (phase),
         .ext_wide (ext_wide),
         .addr_lo  (ext_addr[PORT_W-1:0]),
         .addr_hi  (ext_addr[ADDR_W-1:PORT_W]),
         .wdata    (ext_wdata),
         .ser_en   (ser_en),
         .ser_dir  (ser_dir),
         .ser_out  (ser_out),
         .hi       (drv_hi[p*PORT_W +: PORT_W]),
         .lo       (drv_lo[p*PORT_W +: PORT_W]),
         .pu       (drv_pu[p*PORT_W +: PORT_W])
      );
   end

   ppc_read_mux #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W)
   ) u_rd (
      .latch_q (latch_q),
      .pin_in  (pin_in),
      .rd_sel  (rd_sel),
      .rd_src  (rd_src),
      .rd_data (rd_data)
   );

   // External read data: follows the multiplexed port's pins through the read phase.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ext_rdata <= '0;
      else if (phase == PH_RDATA)  ext_rdata <= pin_in[AD_PORT*PORT_W +: PORT_W];
   end
endmodule

// File: rtl/par_port_ctrl_chk.sv
module par_port_ctrl_chk #(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8,
   parameter int AD_PORT   = 0,
   parameter int AH_PORT   = 2,
   parameter int SER_PORT  = 1,
   localparam int SEL_W = $clog2(NUM_PORTS),
   localparam int BUS_W = NUM_PORTS * PORT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [SEL_W-1:0]  wr_sel,
   input logic [1:0]        wr_op,
   input logic [PORT_W-1:0] wr_data,
   input logic [SEL_W-1:0]  rd_sel,
   input logic              rd_src,
   input logic [PORT_W-1:0] rd_data,
   input logic [1:0]        ext_phase,
   input logic [PORT_W-1:0] ext_rdata,
   input logic [PORT_W-1:0] ser_en,
   input logic [PORT_W-1:0] ser_dir,
   input logic [BUS_W-1:0]  drv_hi,
   input logic [BUS_W-1:0]  drv_lo,
   input logic [BUS_W-1:0]  drv_pu
);
   p_no_contention_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_hi & drv_lo) == '0);

   p_ad_no_pullup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drv_pu[AD_PORT*PORT_W +: PORT_W] == '0);

   p_ad_idle_no_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_phase == 2'd0) |-> (drv_hi[AD_PORT*PORT_W +: PORT_W] == '0));

   p_ad_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_phase == 2'd3) |-> ((drv_hi[AD_PORT*PORT_W +: PORT_W] |
                                drv_lo[AD_PORT*PORT_W +: PORT_W]) == '0));

   p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_phase != 2'd3) |=> $stable(ext_rdata));

   p_ser_in_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ser_en & ~ser_dir) & (drv_hi[SER_PORT*PORT_W +: PORT_W] |
                              drv_lo[SER_PORT*PORT_W +: PORT_W] |
                              drv_pu[SER_PORT*PORT_W +: PORT_W])) == '0);

   p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_op == 2'd0) |=>
         (!(rd_src && rd_sel == $past(wr_sel)) || rd_data == $past(wr_data)));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_quasi
      if (p != AD_PORT && p != AH_PORT && p != SER_PORT) begin : g_chk
         p_quasi_no_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            drv_hi[p*PORT_W +: PORT_W] == '0);
      end
   end
endmodule

bind par_port_ctrl par_port_ctrl_chk #(
   .NUM_PORTS (NUM_PORTS),
   .PORT_W    (PORT_W),
   .AD_PORT   (AD_PORT),
   .AH_PORT   (AH_PORT),
   .SER_PORT  (SER_PORT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_op     (wr_op),
   .wr_data   (wr_data),
   .rd_sel    (rd_sel),
   .rd_src    (rd_src),
   .rd_data   (rd_data),
   .ext_phase (ext_phase),
   .ext_rdata (ext_rdata),
   .ser_en    (ser_en),
   .ser_dir   (ser_dir),
   .drv_hi    (drv_hi),
   .drv_lo    (drv_lo),
   .drv_pu    (drv_pu)
);

// File: tb/sim_par_port_ctrl.sv
module sim_par_port_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [1:0]  wr_op = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic        rd_src = 1'b1;
   logic [7:0]  rd_data;
   logic [1:0]  ext_phase = '0;
   logic        ext_wide = 1'b0;
   logic [15:0] ext_addr = '0;
   logic [7:0]  ext_wdata = '0;
   logic [7:0]  ext_rdata;
   logic [7:0]  ser_en = '0;
   logic [7:0]  ser_dir = '0;
   logic [7:0]  ser_out = '0;
   logic [31:0] pin_in;
   logic [31:0] drv_hi, drv_lo, drv_pu;

   // Outside world: per-pin strong source that only wins over a weak pull-up or a floating pin.
   logic [31:0] ext_drv = '0;
   logic [31:0] ext_val = '0;

   always #2 clk = ~clk;

   for (genvar i = 0; i < 32; i++) begin : g_pin
      assign pin_in[i] = drv_lo[i] ? 1'b0 : drv_hi[i] ? 1'b1 :
                         ext_drv[i] ? ext_val[i] : drv_pu[i];
   end

   par_port_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_op(wr_op),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_src(rd_src), .rd_data(rd_data),
      .ext_phase(ext_phase), .ext_wide(ext_wide), .ext_addr(ext_addr),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ser_en(ser_en),
      .ser_dir(ser_dir), .ser_out(ser_out), .pin_in(pin_in),
      .drv_hi(drv_hi), .drv_lo(drv_lo), .drv_pu(drv_pu)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] m_lat [4];
   logic [7:0] m_rdata = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Expected {hi, lo, pu} for one port from the requirements.
   function automatic logic [23:0] exp_drv(input int p);
      logic [7:0] h, l, u, lat;
      lat = m_lat[p];
      h = 8'h00; l = ~lat; u = lat;            // quasi default (R5)
      if (p == 0) begin
         u = 8'h00;
         case (ext_phase)
            2'd0: begin h = 8'h00; l = ~lat; end             // R4
            2'd1: begin h = ext_addr[7:0]; l = ~ext_addr[7:0]; end // R6
            2'd2: begin h = ext_wdata; l = ~ext_wdata; end    // R6
            default: begin h = 8'h00; l = 8'h00; end          // R7
         endcase
      end else if (p == 2) begin
         if (ext_phase != 2'd0 && ext_wide) begin             // R8
            h = ext_addr[15:8]; l = ~ext_addr[15:8]; u = 8'h00;
         end
      end else if (p == 1) begin
         for (int b = 0; b < 8; b++) begin                    // R9
            if (ser_en[b]) begin
               h[b] = ser_dir[b] & ser_out[b];
               l[b] = ser_dir[b] & ~ser_out[b];
               u[b] = 1'b0;
            end
         end
      end
      return {h, l, u};
   endfunction

   function automatic logic [7:0] exp_pin(input int p);
      logic [23:0] d;
      logic [7:0] v;
      d = exp_drv(p);
      for (int b = 0; b < 8; b++) begin
         v[b] = d[8+b] ? 1'b0 : d[16+b] ? 1'b1 :
                ext_drv[p*8+b] ? ext_val[p*8+b] : d[b];
      end
      return v;
   endfunction

   function automatic logic [7:0] apply_op(input logic [7:0] lat, input logic [1:0] op,
                                           input logic [7:0] d);
      case (op)
         2'd0: return d;
         2'd1: return lat & d;
         2'd2: return lat | d;
         default: return lat ^ d;
      endcase
   endfunction

   function automatic string port_req(input int p);
      if (p == 0) return (ext_phase == 2'd0) ? "R4" : (ext_phase == 2'd3) ? "R7" : "R6";
      if (p == 1) return "R9";
      if (p == 2) return "R8";
      return "R5";
   endfunction

   // Inputs are set before the call (just after a falling edge).
   task automatic step();
      logic [23:0] e, g;
      logic [7:0]  er;
      #1;
      for (int p = 0; p < 4; p++) begin
         e = exp_drv(p);
         g = {drv_hi[p*8 +: 8], drv_lo[p*8 +: 8], drv_pu[p*8 +: 8]};
         chk(g == e, port_req(p), {8'h0, g}, {8'h0, e});
      end
      chk((drv_hi & drv_lo) == '0, "R11", drv_hi & drv_lo, 32'h0);
      er = rd_src ? m_lat[rd_sel] : exp_pin(int'(rd_sel));
      chk(rd_data == er, "R3", {24'h0, rd_data}, {24'h0, er});
      chk(ext_rdata == m_rdata, "R7", {24'h0, ext_rdata}, {24'h0, m_rdata});
      @(posedge clk);
      if (ext_phase == 2'd3) m_rdata = exp_pin(0);
      if (wr_en) m_lat[wr_sel] = apply_op(m_lat[wr_sel], wr_op, wr_data);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      wr_en = 1'b0; ext_phase = 2'd0; ext_wide = 1'b0;
      ser_en = '0; ser_dir = '0; ext_drv = '0;
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0C0D));
      for (int p = 0; p < 4; p++) m_lat[p] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #1;
      chk(drv_pu == 32'hFFFF_FF00, "R1", drv_pu, 32'hFFFF_FF00);
      chk((drv_hi | drv_lo) == 32'h0, "R1", drv_hi | drv_lo, 32'h0);
      @(negedge clk);

      // R2: load into port 3 leaves others untouched
      wr_en = 1'b1; wr_sel = 2'd3; wr_op = 2'd0; wr_data = 8'h5A; step();
      wr_en = 1'b0; rd_src = 1'b1; rd_sel = 2'd3; #1;
      chk(rd_data == 8'h5A, "R2", {24'h0, rd_data}, 32'h5A);
      rd_sel = 2'd1; #1;
      chk(rd_data == 8'hFF, "R2", {24'h0, rd_data}, 32'hFF);
      @(negedge clk);

      // R10: pins pulled low externally must not corrupt latch ones on OR/AND
      ext_drv = 32'h0000_0F00; ext_val = 32'h0;
      wr_en = 1'b1; wr_sel = 2'd1; wr_op = 2'd2; wr_data = 8'h00; step();
      wr_en = 1'b0; rd_sel = 2'd1; rd_src = 1'b1; #1;
      chk(rd_data == 8'hFF, "R10", {24'h0, rd_data}, 32'hFF);
      rd_src = 1'b0; #1;
      chk(rd_data == 8'hF0, "R3", {24'h0, rd_data}, 32'hF0);
      @(negedge clk);
      wr_en = 1'b1; wr_op = 2'd1; wr_data = 8'hFF; step();
      wr_en = 1'b1; wr_op = 2'd3; wr_data = 8'h3C; step();
      wr_en = 1'b0; rd_src = 1'b1; #1;
      chk(rd_data == 8'hC3, "R10", {24'h0, rd_data}, 32'hC3);
      @(negedge clk);
      ext_drv = '0;

      // R6 / R8 / R7: a wide external write then read, port 0 latch untouched
      ext_addr = 16'h12AB; ext_wdata = 8'h3E; ext_wide = 1'b1;
      ext_phase = 2'd1; step();
      ext_phase = 2'd2; step();
      ext_drv = 32'h0000_00FF; ext_val = 32'h0000_0096;
      ext_phase = 2'd3; step();
      ext_phase = 2'd0; ext_wide = 1'b0; ext_drv = '0; #1;
      chk(ext_rdata == 8'h96, "R7", {24'h0, ext_rdata}, 32'h96);
      rd_sel = 2'd0; rd_src = 1'b1; #1;
      chk(rd_data == 8'hFF, "R7", {24'h0, rd_data}, 32'hFF);
      @(negedge clk);
      // narrow address: port 2 stays on its latch
      ext_phase = 2'd1; ext_wide = 1'b0; step();
      idle_inputs();

      // Constrained random mix
      for (int i = 0; i < 800; i++) begin
         wr_en     = ($urandom_range(0, 2) == 0);
         wr_sel    = 2'($urandom_range(0, 3));
         wr_op     = 2'($urandom_range(0, 3));
         wr_data   = 8'($urandom);
         rd_sel    = 2'($urandom_range(0, 3));
         rd_src    = 1'($urandom_range(0, 1));
         ext_phase = 2'($urandom_range(0, 3));
         ext_wide  = 1'($urandom_range(0, 1));
         ext_addr  = 16'($urandom);
         ext_wdata = 8'($urandom);
         ser_en    = 8'($urandom);
         ser_dir   = 8'($urandom);
         ser_out   = 8'($urandom);
         ext_drv   = ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom;
         ext_val   = $urandom;
         step();
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule